// File: doc/BRIEF.md
# Dual-Width Arithmetic Flag Generator

This unit computes and holds the negative and overflow status flags of a processor core whose operand width is chosen at run time. A data-length mode bit selects whether results are judged at the 8-bit boundary or at the 16-bit boundary. The core's adder, divider and register file stay outside the unit. The unit receives an operation class, the two operands and the result, a decimal-mode indication and a divide-overflow indication. From these it updates the flags on the next clock edge. An index-length mode bit is held in the same register bank.

Flag-manipulation instructions reach the unit as per-flag set and clear masks. Two dedicated strobes also exist: one clears overflow and one clears the data-length bit. These strobes take priority over any arithmetic update made in the same cycle. Four branch-condition outputs follow the registered flags, so a branch unit can test overflow-clear, overflow-set, plus and minus without decoding the flag bits.

Top module: `status_flag_unit`

## Requirements
- R1: After reset, negative, overflow, data-length and index-length are all 0.
- R2: With data-length at 0, add (op 3'b001) and subtract (op 3'b010) set overflow exactly when the signed 16-bit result of a+b or a-b lies outside -32768..+32767, and clear it otherwise.
- R3: With data-length at 1, add and subtract judge overflow on the low bytes only, against -128..+127. The upper bytes of the operands and of the result have no effect.
- R4: Add, subtract and transfer (op 3'b011) load negative from result bit 15 when data-length is 0, and from result bit 7 when it is 1. A transfer leaves overflow unchanged.
- R5: Divide (op 3'b100) loads overflow from the divide-overflow input, leaves negative unchanged, and does so whatever the decimal-mode input is.
- R6: While decimal mode is 1, add and subtract leave negative and overflow unchanged. A transfer still updates negative.
- R7: Mask bit 0 addresses negative, bit 1 overflow, bit 2 data-length and bit 3 index-length. A set-mask bit forces its flag to 1 and a clear-mask bit forces it to 0. The dedicated clear strobes clear overflow and data-length. When set and clear address the same flag in one cycle, the flag becomes 1.
- R8: A set or clear for negative or overflow overrides an arithmetic, transfer or divide update of that flag in the same cycle.
- R9: Index-length changes only through its set and clear mask bits. It does not alter the width used for flag tests.
- R10: The branch outputs follow the registered flags: overflow-clear is the inverse of overflow, overflow-set equals overflow, plus is the inverse of negative, and minus equals negative.
- R11: Op codes 3'b000 and 3'b101 to 3'b111 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 transfer, 4 divide |
| opnd_a | input | 16 | First adder operand |
| opnd_b | input | 16 | Second adder operand, not inverted for subtract |
| result | input | 16 | Operation result |
| dec_mode | input | 1 | Decimal mode active |
| div_ovf | input | 1 | Divide quotient does not fit its destination |
| set_mask | input | 4 | Per-flag set strobes |
| clr_mask | input | 4 | Per-flag clear strobes |
| clr_ovf | input | 1 | Dedicated overflow clear |
| clr_dlen | input | 1 | Dedicated data-length clear |
| neg_flag | output | 1 | Negative flag |
| ovf_flag | output | 1 | Overflow flag |
| dlen_flag | output | 1 | Data-length flag, 1 selects 8-bit |
| ilen_flag | output | 1 | Index-length flag, 1 selects 8-bit |
| br_vc | output | 1 | Overflow-clear branch condition |
| br_vs | output | 1 | Overflow-set branch condition |
| br_pl | output | 1 | Plus branch condition |
| br_mi | output | 1 | Minus branch condition |

## Verification
All state in the unit is visible directly on the flag outputs, so a wrong internal value shows up one clock after the operation that produced it. A corrupted data-length bit shows itself indirectly as well. The next operation then picks its sign bit from the wrong byte, so a single add whose two bytes disagree about overflow exposes a stale mode. Lost priority between strobe and arithmetic, or a decimal mode that fails to suppress updates, likewise shows on the overflow and negative outputs in the cycle after the conflict.

// File: rtl/status_flag_unit.sv
module status_flag_unit #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] result,
  input  logic          dec_mode,
  input  logic          div_ovf,
  input  logic [3:0]    set_mask,
  input  logic [3:0]    clr_mask,
  input  logic          clr_ovf,
  input  logic          clr_dlen,
  output logic          neg_flag,
  output logic          ovf_flag,
  output logic          dlen_flag,
  output logic          ilen_flag,
  output logic          br_vc,
  output logic          br_vs,
  output logic          br_pl,
  output logic          br_mi
);
  localparam int HI = DW - 1;
  localparam int LO = NW - 1;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_XFR = 3'd3;
  localparam logic [2:0] OP_DIV = 3'd4;

  logic a_s, b_s, r_s, ar_ovf;
  logic neg_nx, ovf_nx, dlen_nx, ilen_nx;

  assign a_s    = dlen_flag ? opnd_a[LO] : opnd_a[HI];
  assign b_s    = (dlen_flag ? opnd_b[LO] : opnd_b[HI]) ^ (op == OP_SUB);
  assign r_s    = dlen_flag ? result[LO] : result[HI];
  assign ar_ovf = (a_s == b_s) && (r_s != a_s);

  always_comb begin
    neg_nx  = neg_flag;
    ovf_nx  = ovf_flag;
    dlen_nx = dlen_flag;
    ilen_nx = ilen_flag;
    case (op)
      OP_ADD, OP_SUB: if (!dec_mode) begin
        neg_nx = r_s;
        ovf_nx = ar_ovf;
      end
      OP_XFR:  neg_nx = r_s;
      OP_DIV:  ovf_nx = div_ovf;
      default: ;
    endcase
    if (clr_mask[0])             neg_nx  = 1'b0;
    if (clr_mask[1] || clr_ovf)  ovf_nx  = 1'b0;
    if (clr_mask[2] || clr_dlen) dlen_nx = 1'b0;
    if (clr_mask[3])             ilen_nx = 1'b0;
    if (set_mask[0]) neg_nx  = 1'b1;
    if (set_mask[1]) ovf_nx  = 1'b1;
    if (set_mask[2]) dlen_nx = 1'b1;
    if (set_mask[3]) ilen_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
      dlen_flag <= 1'b0;
      ilen_flag <= 1'b0;
    end else begin
      neg_flag  <= neg_nx;
      ovf_flag  <= ovf_nx;
      dlen_flag <= dlen_nx;
      ilen_flag <= ilen_nx;
    end
  end

  assign br_vc = ~ovf_flag;
  assign br_vs = ovf_flag;
  assign br_pl = ~neg_flag;
  assign br_mi = neg_flag;

  AST_SET_OVF: assert property (@(posedge clk) disable iff (!rst_n) set_mask[1] |=> ovf_flag); // R7
  AST_CLR_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_ovf && !set_mask[1]) |=> !ovf_flag); // R8
  AST_DIV_OVF: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_DIV && div_ovf && !clr_mask[1] && !clr_ovf) |=> ovf_flag); // R5
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dec_mode && (op == OP_ADD || op == OP_SUB) && set_mask[1:0] == 2'b00 && clr_mask[1:0] == 2'b00 && !clr_ovf) |=> ($stable(neg_flag) && $stable(ovf_flag))); // R6
  AST_ILEN_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (!set_mask[3] && !clr_mask[3]) |=> $stable(ilen_flag)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((op == 3'd0 || op > OP_DIV) && set_mask == 4'd0 && clr_mask == 4'd0 && !clr_ovf && !clr_dlen) |=> $stable({neg_flag, ovf_flag, dlen_flag, ilen_flag})); // R11
endmodule

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opnd_a = 16'd0, opnd_b = 16'd0, result = 16'd0;
  logic        dec_mode = 1'b0, div_ovf = 1'b0, clr_ovf = 1'b0, clr_dlen = 1'b0;
  logic [3:0]  set_mask = 4'd0, clr_mask = 4'd0;
  logic        neg_flag, ovf_flag, dlen_flag, ilen_flag, br_vc, br_vs, br_pl, br_mi;
  int checks = 0, fails = 0;
  logic e_neg = 0, e_ovf = 0, e_dlen = 0, e_ilen = 0;

  always #10 clk = ~clk;

  status_flag_unit i_status_flag_unit (
    .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .dec_mode(dec_mode), .div_ovf(div_ovf), .set_mask(set_mask), .clr_mask(clr_mask),
    .clr_ovf(clr_ovf), .clr_dlen(clr_dlen), .neg_flag(neg_flag), .ovf_flag(ovf_flag),
    .dlen_flag(dlen_flag), .ilen_flag(ilen_flag), .br_vc(br_vc), .br_vs(br_vs),
    .br_pl(br_pl), .br_mi(br_mi));

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, neg_flag, e_neg, "neg");
    chk(req, ovf_flag, e_ovf, "ovf");
    chk(req, dlen_flag, e_dlen, "dlen");
    chk(req, ilen_flag, e_ilen, "ilen");
    chk("R10", br_vc, ~e_ovf, "br_vc");
    chk("R10", br_vs, e_ovf, "br_vs");
    chk("R10", br_pl, ~e_neg, "br_pl");
    chk("R10", br_mi, e_neg, "br_mi");
  endtask

  task automatic idle();
    op = 3'd0; dec_mode = 0; div_ovf = 0; set_mask = 0; clr_mask = 0; clr_ovf = 0; clr_dlen = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic strobe(logic [3:0] s, logic [3:0] c, logic cv, logic cd);
    set_mask = s; clr_mask = c; clr_ovf = cv; clr_dlen = cd;
    cycle();
  endtask

  task automatic arith(string req, logic sub, logic [15:0] a, logic [15:0] b, logic dec);
    int sa, sb, r;
    logic [15:0] res;
    res = sub ? a - b : a + b;
    if (e_dlen) begin
      sa = $signed(a[7:0]); sb = $signed(b[7:0]);
    end else begin
      sa = $signed(a); sb = $signed(b);
    end
    r = sub ? sa - sb : sa + sb;
    op = sub ? 3'd2 : 3'd1; opnd_a = a; opnd_b = b; result = res; dec_mode = dec;
    cycle();
    if (!dec) begin
      e_ovf = e_dlen ? (r > 127 || r < -128) : (r > 32767 || r < -32768);
      e_neg = e_dlen ? res[7] : res[15];
    end
    chk_all(req);
  endtask

  task automatic t_reset();
    chk_all("R1");
  endtask

  task automatic t_wide();
    arith("R2", 0, 16'h7FFF, 16'h0001, 0);
    arith("R2", 0, 16'h8000, 16'hFFFF, 0);
    arith("R2", 0, 16'h1234, 16'h0001, 0);
    arith("R2", 1, 16'h8000, 16'h0001, 0);
    arith("R4", 1, 16'h0005, 16'h0007, 0);
    arith("R2", 1, 16'h7FFF, 16'hFFFF, 0);
  endtask

  task automatic t_narrow();
    strobe(4'b0100, 0, 0, 0); e_dlen = 1; chk_all("R7");
    arith("R3", 0, 16'h127F, 16'hAB01, 0);
    arith("R3", 0, 16'h7F10, 16'h7F20, 0);
    arith("R3", 1, 16'h0080, 16'h0001, 0);
    arith("R4", 1, 16'h8003, 16'h0005, 0);
    strobe(0, 0, 0, 1); e_dlen = 0; chk_all("R7");
  endtask

  task automatic t_xfer();
    strobe(4'b0010, 0, 0, 0); e_ovf = 1; chk_all("R7");
    op = 3'd3; result = 16'h8000; cycle(); e_neg = 1; chk_all("R4");
    strobe(4'b0100, 0, 0, 0); e_dlen = 1;
    op = 3'd3; result = 16'h8000; cycle(); e_neg = 0; chk_all("R4");
    op = 3'd3; result = 16'h0080; cycle(); e_neg = 1; chk_all("R4");
    strobe(0, 4'b0100, 0, 0); e_dlen = 0; chk_all("R7");
  endtask

  task automatic t_div();
    e_neg = neg_flag;
    op = 3'd4; div_ovf = 0; result = 16'h8000; cycle(); e_ovf = 0; chk_all("R5");
    op = 3'd4; div_ovf = 1; cycle(); e_ovf = 1; chk_all("R5");
    op = 3'd4; div_ovf = 0; dec_mode = 1; cycle(); e_ovf = 0; chk_all("R5");
    op = 3'd4; div_ovf = 1; dec_mode = 1; cycle(); e_ovf = 1; chk_all("R5");
  endtask

  task automatic t_decimal();
    arith("R6", 0, 16'h7FFF, 16'h0001, 1);
    arith("R6", 1, 16'h0001, 16'h0003, 1);
    op = 3'd3; dec_mode = 1; result = 16'h0001; cycle(); e_neg = 0; chk_all("R6");
  endtask

  task automatic t_strobes();
    strobe(4'b1111, 0, 0, 0); e_neg = 1; e_ovf = 1; e_dlen = 1; e_ilen = 1; chk_all("R7");
    strobe(0, 0, 1, 0); e_ovf = 0; chk_all("R7");
    strobe(0, 4'b1001, 0, 0); e_neg = 0; e_ilen = 0; chk_all("R7");
    strobe(4'b0011, 4'b0011, 0, 0); e_neg = 1; e_ovf = 1; chk_all("R7");
    strobe(0, 4'b1111, 0, 0); e_neg = 0; e_ovf = 0; e_dlen = 0; chk_all("R7");
  endtask

  task automatic t_priority();
    op = 3'd1; opnd_a = 16'h0001; opnd_b = 16'h0001; result = 16'h0002; set_mask = 4'b0011;
    cycle(); e_neg = 1; e_ovf = 1; chk_all("R8");
    op = 3'd1; opnd_a = 16'h7FFF; opnd_b = 16'h0001; result = 16'h8000; clr_ovf = 1; clr_mask = 4'b0001;
    cycle(); e_neg = 0; e_ovf = 0; chk_all("R8");
    op = 3'd4; div_ovf = 1; clr_mask = 4'b0010; cycle(); chk_all("R8");
  endtask

  task automatic t_index();
    strobe(4'b1000, 0, 0, 0); e_ilen = 1; chk_all("R9");
    arith("R9", 0, 16'h007F, 16'h0001, 0);
    op = 3'd3; result = 16'h0080; cycle(); e_neg = 0; chk_all("R9");
    strobe(0, 0, 1, 1); e_ovf = 0; chk_all("R9");
    strobe(0, 4'b1000, 0, 0); e_ilen = 0; chk_all("R9");
  endtask

  task automatic t_reserved();
    strobe(4'b0011, 0, 0, 0); e_neg = 1; e_ovf = 1;
    for (int k = 5; k < 8; k++) begin
      op = 3'(k); opnd_a = 16'h0001; opnd_b = 16'h0001; result = 16'h0002; div_ovf = 0;
      cycle(); chk_all("R11");
    end
    op = 3'd0; result = 16'h0000; cycle(); chk_all("R11");
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wide();
    t_narrow();
    t_xfer();
    t_div();
    t_decimal();
    t_strobes();
    t_priority();
    t_index();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule